// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block writes a stored image into a UV-erasable, byte-wide EPROM that sits in a programmer socket. A single start pulse launches the whole job. First the sequencer reads every location to confirm that the device is erased. It then steps through the addresses in ascending order. At each address it fetches the target byte from an image port, fires timed active-low program pulses and reads the byte back after each one. When the last byte is written, it reads the whole device back twice more: once with the supplies raised to a high margin level, and once with them lowered to a low margin level.

The analog supplies live outside the block. The sequencer only presents a two-bit level request to them. All timing windows are counted in clock cycles, derived from the clock frequency parameter. When the job ends, the sequencer drops back to idle and holds one of three outcomes: pass, device failure or not blank. A failing outcome also holds the failing address. These results stay valid until the next start.

Top module: `eprom_prog_seq`

## Requirements
- R1: Out of reset and whenever idle, busy, done, fail and not_blank are low, ep_ce_n, ep_oe_n and ep_pgm_n are high, and supply_sel is 00.
- R2: After start, every address from 0 upward is read with supply_sel = 00 before any program pulse. The first byte that is not 0xFF stops the job with not_blank high, fail low, fail_addr set to that address, and no pulse issued at all.
- R3: Each program pulse holds ep_pgm_n low for exactly PULSE_US x CLK_HZ / 1e6 cycles, never longer. During the pulse ep_ce_n is low, ep_oe_n is high and supply_sel is 01, the programming level.
- R4: ep_addr, ep_din, ep_oe_n and ep_ce_n are steady for at least SETUP_US x CLK_HZ / 1e6 cycles before ep_pgm_n falls and stay steady while it is low. ep_addr and ep_din are held for at least HOLD_US x CLK_HZ / 1e6 cycles after it rises.
- R5: After every pulse the byte is read back with ep_ce_n and ep_oe_n low, ep_pgm_n high and supply_sel still 01. A match moves on to the next address, so each address receives exactly as many pulses as it needs. A target of 0xFF takes one pulse.
- R6: If a byte still mismatches after MAX_PULSES pulses, the job stops with fail high and fail_addr set to that address, and later addresses are left untouched. A byte that matches on exactly the MAX_PULSES-th pulse passes.
- R7: If a read-back shows a bit at 0 where the target has a 1, the job stops with fail at once, without a further pulse.
- R8: After the last address, all bytes are read and compared at supply_sel = 10 (high margin). Only after that pass completes are they all read again at supply_sel = 11 (low margin). Any mismatch stops the job with fail and fail_addr.
- R9: The target byte for an address is taken one clock after img_addr presents it (synchronous read). A job that clears all checks ends with done high and the device holding the image.
- R10: start is ignored while busy. A start accepted from idle clears done, fail and not_blank. At most one of these is high when busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a job (acted on only when idle) |
| img_addr | output | ADDR_W | Address into the image store |
| img_data | input | DATA_W | Image byte, valid one clock after img_addr |
| ep_addr | output | ADDR_W | Device address lines |
| ep_din | output | DATA_W | Byte driven toward the device for programming |
| ep_dout | input | DATA_W | Byte read from the device |
| ep_ce_n | output | 1 | Device chip enable, active low |
| ep_oe_n | output | 1 | Device output enable, active low |
| ep_pgm_n | output | 1 | Device program strobe, active low |
| supply_sel | output | 2 | Supply level request: 00 read, 01 program, 10 high margin, 11 low margin |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job passed |
| fail | output | 1 | Last job found a failing device |
| not_blank | output | 1 | Last job stopped at blank check |
| fail_addr | output | ADDR_W | Address that caused fail or not_blank |

## Verification
The bench's socket model lets each address demand a chosen number of pulses. This targets the retry cap at MAX_PULSES and at MAX_PULSES + 1: a design with an off-by-one counter would fail a good byte or pass a hopeless one, and the per-address pulse tally shows which. Other faults injected by the model are a bit that programs to zero by accident, and bytes that misread only at the high or only at the low margin level. A sequencer that retried stuck bits, skipped a margin pass or ran the passes in the wrong order would then report the wrong address or the wrong count of margin reads. Non-blank bytes are placed at a middle address and at the last address, and a second start is issued mid-job; a design that restarted would fail the blank check on its own programmed bytes.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_READ
    } seq_state_e;

    // Phase code doubles as the supply level request while busy.
    typedef enum logic [1:0] {
        PH_BLANK = 2'b00,
        PH_PROG  = 2'b01,
        PH_MHI   = 2'b10,
        PH_MLO   = 2'b11
    } seq_phase_e;

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_delay_timer.sv
module eprom_delay_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/eprom_pulse_tally.sv
module eprom_pulse_tally #(
    parameter int CAP = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_cap
);

    localparam int CNT_W = $clog2(CAP + 1);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != CAP_V)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_cap = (cnt_q == CAP_V);

endmodule

// File: rtl/eprom_byte_judge.sv
module eprom_byte_judge #(
    parameter int DATA_W = 8
) (
    input  logic              want_erased,
    input  logic [DATA_W-1:0] target,
    input  logic [DATA_W-1:0] seen,
    output logic              match,
    output logic              stuck
);

    logic [DATA_W-1:0] expect_v;

    always_comb begin
        expect_v = want_erased ? {DATA_W{1'b1}} : target;
        match    = (seen == expect_v);
        // A wanted 1 over a stored 0 can never be repaired by more pulses.
        stuck    = |(expect_v & ~seen);
    end

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int PULSE_US   = 100,
    parameter int SETUP_US   = 2,
    parameter int HOLD_US    = 2,
    parameter int READ_US    = 2,
    parameter int MAX_PULSES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] img_addr,
    input  logic [DATA_W-1:0] img_data,
    output logic [ADDR_W-1:0] ep_addr,
    output logic [DATA_W-1:0] ep_din,
    input  logic [DATA_W-1:0] ep_dout,
    output logic              ep_ce_n,
    output logic              ep_oe_n,
    output logic              ep_pgm_n,
    output logic [1:0]        supply_sel,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              not_blank,
    output logic [ADDR_W-1:0] fail_addr
);

    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int PULSE_CYC  = at_least_one(PULSE_US * CYC_PER_US);
    localparam int SETUP_CYC  = at_least_one(SETUP_US * CYC_PER_US);
    localparam int HOLD_CYC   = at_least_one(HOLD_US * CYC_PER_US);
    localparam int READ_CYC   = at_least_one(READ_US * CYC_PER_US);
    localparam int FETCH_CYC  = 2;
    localparam int LONGEST    = max_of(max_of(PULSE_CYC, SETUP_CYC),
                                       max_of(HOLD_CYC, READ_CYC));
    localparam int TMR_W      = $clog2(LONGEST + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    localparam logic [TMR_W-1:0] T_FETCH = TMR_W'(FETCH_CYC - 1);
    localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] T_PULSE = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] T_HOLD  = TMR_W'(HOLD_CYC - 1);
    localparam logic [TMR_W-1:0] T_READ  = TMR_W'(READ_CYC - 1);

    typedef struct packed {
        seq_state_e        state;
        seq_phase_e        phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] tgt;
        logic              done;
        logic              fail;
        logic              blank_err;
        logic [ADDR_W-1:0] fail_addr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             tally_clr;
    logic             tally_inc;
    logic             tally_full;
    logic             byte_ok;
    logic             byte_stuck;
    logic             advance;

    eprom_delay_timer #(.WIDTH(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    eprom_pulse_tally #(.CAP(MAX_PULSES)) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tally_clr),
        .inc    (tally_inc),
        .at_cap (tally_full)
    );

    eprom_byte_judge #(.DATA_W(DATA_W)) u_judge (
        .want_erased (r_q.phase == PH_BLANK),
        .target      (r_q.tgt),
        .seen        (ep_dout),
        .match       (byte_ok),
        .stuck       (byte_stuck)
    );

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        tally_clr = 1'b0;
        tally_inc = 1'b0;
        advance   = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state     = ST_FETCH;
                    r_d.phase     = PH_BLANK;
                    r_d.addr      = '0;
                    r_d.done      = 1'b0;
                    r_d.fail      = 1'b0;
                    r_d.blank_err = 1'b0;
                    r_d.fail_addr = '0;
                    tmr_load      = 1'b1;
                    tmr_val       = T_FETCH;
                    tally_clr     = 1'b1;
                end
            end

            ST_FETCH: begin
                if (tmr_zero) begin
                    r_d.tgt  = img_data;
                    tmr_load = 1'b1;
                    if (r_q.phase == PH_PROG) begin
                        r_d.state = ST_SETUP;
                        tmr_val   = T_SETUP;
                    end else begin
                        r_d.state = ST_READ;
                        tmr_val   = T_READ;
                    end
                end
            end

            ST_SETUP: begin
                if (tmr_zero) begin
                    r_d.state = ST_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = T_PULSE;
                end
            end

            ST_PULSE: begin
                if (tmr_zero) begin
                    r_d.state = ST_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = T_HOLD;
                    tally_inc = 1'b1;
                end
            end

            ST_HOLD: begin
                if (tmr_zero) begin
                    r_d.state = ST_READ;
                    tmr_load  = 1'b1;
                    tmr_val   = T_READ;
                end
            end

            ST_READ: begin
                if (tmr_zero) begin
                    unique case (r_q.phase)
                        PH_BLANK: begin
                            if (!byte_ok) begin
                                r_d.state     = ST_IDLE;
                                r_d.blank_err = 1'b1;
                                r_d.fail_addr = r_q.addr;
                            end else begin
                                advance = 1'b1;
                            end
                        end
                        PH_PROG: begin
                            if (byte_ok) begin
                                advance = 1'b1;
                            end else if (byte_stuck || tally_full) begin
                                r_d.state     = ST_IDLE;
                                r_d.fail      = 1'b1;
                                r_d.fail_addr = r_q.addr;
                            end else begin
                                r_d.state = ST_SETUP;
                                tmr_load  = 1'b1;
                                tmr_val   = T_SETUP;
                            end
                        end
                        default: begin
                            if (!byte_ok) begin
                                r_d.state     = ST_IDLE;
                                r_d.fail      = 1'b1;
                                r_d.fail_addr = r_q.addr;
                            end else begin
                                advance = 1'b1;
                            end
                        end
                    endcase

                    if (advance) begin
                        r_d.state = ST_FETCH;
                        tmr_load  = 1'b1;
                        tmr_val   = T_FETCH;
                        tally_clr = 1'b1;
                        if (r_q.addr == LAST_ADDR) begin
                            r_d.addr = '0;
                            if (r_q.phase == PH_MLO) begin
                                r_d.state = ST_IDLE;
                                r_d.done  = 1'b1;
                                tmr_load  = 1'b0;
                            end else begin
                                r_d.phase = seq_phase_e'(r_q.phase + 2'd1);
                            end
                        end else begin
                            r_d.addr = r_q.addr + 1'b1;
                        end
                    end
                end
            end

            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, phase: PH_BLANK, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.state != ST_IDLE);
    assign ep_ce_n    = !busy;
    assign ep_oe_n    = (r_q.state != ST_READ);
    assign ep_pgm_n   = (r_q.state != ST_PULSE);
    assign supply_sel = busy ? r_q.phase : PH_BLANK;
    assign ep_addr    = r_q.addr;
    assign img_addr   = r_q.addr;
    assign ep_din     = r_q.tgt;
    assign done       = r_q.done;
    assign fail       = r_q.fail;
    assign not_blank  = r_q.blank_err;
    assign fail_addr  = r_q.fail_addr;

endmodule

// File: rtl/eprom_prog_seq_checker.sv
module eprom_prog_seq_checker
    import eprom_prog_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int PULSE_US = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              not_blank,
    input logic              ep_ce_n,
    input logic              ep_oe_n,
    input logic              ep_pgm_n,
    input logic [1:0]        supply_sel,
    input logic [ADDR_W-1:0] ep_addr,
    input logic [DATA_W-1:0] ep_din
);

    localparam int PULSE_CYC = at_least_one(PULSE_US * (CLK_HZ / 1_000_000));

    logic [31:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!ep_pgm_n) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ep_ce_n && ep_oe_n && ep_pgm_n && supply_sel == 2'b00));

    a_r3_pulse_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_pgm_n |-> (!ep_ce_n && ep_oe_n && supply_sel == 2'b01));

    a_r3_no_dc_level: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_pgm_n |-> (low_cnt < PULSE_CYC));

    a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_pgm_n && low_cnt != 0) |-> (low_cnt == PULSE_CYC));

    a_r4_steady_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!ep_pgm_n && low_cnt != 0) |-> ($stable(ep_din) && $stable(ep_addr)));

    a_r5_read_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_oe_n |-> (!ep_ce_n && ep_pgm_n));

    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $onehot({done, fail, not_blank}));

endmodule

bind eprom_prog_seq eprom_prog_seq_checker #(
    .CLK_HZ   (CLK_HZ),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PULSE_US (PULSE_US)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .not_blank  (not_blank),
    .ep_ce_n    (ep_ce_n),
    .ep_oe_n    (ep_oe_n),
    .ep_pgm_n   (ep_pgm_n),
    .supply_sel (supply_sel),
    .ep_addr    (ep_addr),
    .ep_din     (ep_din)
);

// File: tb/eprom_prog_seq_bench.sv
module eprom_prog_seq_bench;

    localparam int CLK_HZ    = 1_000_000;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int MAXP      = 20;
    localparam int PULSE_CYC = 100;
    localparam int SETUP_CYC = 2;
    localparam int HOLD_CYC  = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n, start;
    logic [ADDR_W-1:0] img_addr, ep_addr, fail_addr;
    logic [DATA_W-1:0] img_data, ep_din, ep_dout;
    logic              ep_ce_n, ep_oe_n, ep_pgm_n, busy, done, fail, not_blank;
    logic [1:0]        supply_sel;

    eprom_prog_seq #(
        .CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PULSE_US(100), .SETUP_US(2), .HOLD_US(2), .READ_US(2), .MAX_PULSES(MAXP)
    ) u_eprom_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .img_addr(img_addr), .img_data(img_data),
        .ep_addr(ep_addr), .ep_din(ep_din), .ep_dout(ep_dout),
        .ep_ce_n(ep_ce_n), .ep_oe_n(ep_oe_n), .ep_pgm_n(ep_pgm_n),
        .supply_sel(supply_sel), .busy(busy), .done(done), .fail(fail),
        .not_blank(not_blank), .fail_addr(fail_addr)
    );

    // Image store and socket model
    logic [7:0] img     [DEPTH];
    logic [7:0] mem     [DEPTH];
    logic [7:0] xclr    [DEPTH];
    logic [7:0] weak_hi [DEPTH];
    logic [7:0] weak_lo [DEPTH];
    int         need    [DEPTH];
    int         cnt     [DEPTH];
    int         pcnt    [DEPTH];

    always @(posedge clk) img_data <= img[img_addr];

    assign ep_dout = (!ep_ce_n && !ep_oe_n)
                   ? (mem[ep_addr] ^ (supply_sel == 2'b10 ? weak_hi[ep_addr] :
                                      supply_sel == 2'b11 ? weak_lo[ep_addr] : 8'h00))
                   : 8'h5A;

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor state
    logic [ADDR_W+DATA_W+1:0] prev_sig;
    logic [ADDR_W+DATA_W-1:0] prev_hold;
    logic       prev_pgm = 1'b1, prev_oe = 1'b1, pulsed = 1'b0;
    int         setup_run = 0, low_run = 0, hi_run = 0;
    int         reads_blank = 0, reads_hi = 0, reads_lo = 0, total_pulses = 0;
    int         max_sup = 0;
    logic [7:0] fall_din;
    logic [ADDR_W-1:0] fall_addr;
    logic       fall_ok;

    always @(negedge clk) begin
        logic [ADDR_W+DATA_W+1:0] sig;
        logic [ADDR_W+DATA_W-1:0] hsig;
        if (rst_n) begin
            sig  = {ep_addr, ep_din, ep_oe_n, ep_ce_n};
            hsig = {ep_addr, ep_din};
            if (int'(supply_sel) > max_sup) max_sup = int'(supply_sel);
            if (!ep_pgm_n && prev_pgm) begin
                chk("R4 setup before pulse", sig == prev_sig && setup_run >= SETUP_CYC,
                    setup_run, SETUP_CYC);
                chk("R3 levels at pulse", !ep_ce_n && ep_oe_n && supply_sel == 2'b01,
                    int'(supply_sel), 1);
                chk("R2 blank reads precede first pulse", pulsed || reads_blank == DEPTH,
                    reads_blank, DEPTH);
                fall_din  = ep_din;
                fall_addr = ep_addr;
                fall_ok   = !ep_ce_n && ep_oe_n && supply_sel == 2'b01;
                low_run   = 0;
                pulsed    = 1'b1;
            end
            if (!ep_pgm_n) begin
                low_run++;
                if (!prev_pgm && sig != prev_sig) chk("R4 lines moved in pulse", 1'b0, 1, 0);
            end
            if (ep_pgm_n && !prev_pgm) begin
                chk("R3 pulse width", low_run == PULSE_CYC, low_run, PULSE_CYC);
                total_pulses++;
                pcnt[fall_addr]++;
                cnt[fall_addr]++;
                if (fall_ok && cnt[fall_addr] >= need[fall_addr])
                    mem[fall_addr] = mem[fall_addr] & fall_din & ~xclr[fall_addr];
                hi_run = 0;
            end
            if (ep_pgm_n && pulsed && hsig != prev_hold)
                chk("R4 hold after pulse", hi_run >= HOLD_CYC, hi_run, HOLD_CYC);
            if (ep_pgm_n) hi_run++;
            if (!ep_oe_n && prev_oe) begin
                chk("R5 read levels", ep_pgm_n && !ep_ce_n, int'(ep_pgm_n), 1);
                case (supply_sel)
                    2'b00: reads_blank++;
                    2'b10: reads_hi++;
                    2'b11: begin
                        if (reads_lo == 0)
                            chk("R8 high pass complete before low", reads_hi == DEPTH,
                                reads_hi, DEPTH);
                        reads_lo++;
                    end
                    default: ;
                endcase
            end
            setup_run = (sig == prev_sig) ? setup_run + 1 : 1;
            prev_sig  = sig;
            prev_hold = hsig;
            prev_pgm  = ep_pgm_n;
            prev_oe   = ep_oe_n;
        end
    end

    task automatic prep(input int pattern);
        for (int a = 0; a < DEPTH; a++) begin
            case (pattern)
                0: img[a] = 8'(a * 37) ^ 8'hA5;
                1: img[a] = ~8'(a);
                default: img[a] = 8'h11 << (a % 4);
            endcase
            mem[a] = 8'hFF; xclr[a] = 8'h00; weak_hi[a] = 8'h00; weak_lo[a] = 8'h00;
            need[a] = 1; cnt[a] = 0; pcnt[a] = 0;
        end
        reads_blank = 0; reads_hi = 0; reads_lo = 0; total_pulses = 0;
        max_sup = 0; pulsed = 1'b0;
    endtask

    function automatic int exp_pulses(input int a);
        if (img[a] == 8'hFF) return 1;
        return (need[a] > MAXP) ? MAXP : need[a];
    endfunction

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R10 start clears status", busy && !done && !fail && !not_blank,
            int'({busy, done, fail, not_blank}), 8);
    endtask

    task automatic finish_wait();
        int n = 0;
        while (busy && n < 60000) begin
            @(negedge clk);
            n++;
        end
        chk("watchdog", !busy, n, 0);
        @(negedge clk);
    endtask

    task automatic expect_pass(input string tag);
        chk({tag, " R9 done"}, done && !fail && !not_blank, int'({done, fail, not_blank}), 4);
        for (int a = 0; a < DEPTH; a++) begin
            chk({tag, " R9 image written"}, mem[a] == img[a], int'(mem[a]), int'(img[a]));
            chk({tag, " R5 pulses per address"}, pcnt[a] == exp_pulses(a), pcnt[a], exp_pulses(a));
        end
        chk({tag, " R2 blank reads"}, reads_blank == DEPTH, reads_blank, DEPTH);
        chk({tag, " R8 high margin reads"}, reads_hi == DEPTH, reads_hi, DEPTH);
        chk({tag, " R8 low margin reads"}, reads_lo == DEPTH, reads_lo, DEPTH);
    endtask

    task automatic expect_fail(input string tag, input int addr);
        chk({tag, " fail flag"}, fail && !done && !not_blank, int'({done, fail, not_blank}), 2);
        chk({tag, " fail_addr"}, int'(fail_addr) == addr, int'(fail_addr), addr);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        prep(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status idle", !busy && !done && !fail && !not_blank,
            int'({busy, done, fail, not_blank}), 0);
        chk("R1 strobes high", ep_ce_n && ep_oe_n && ep_pgm_n,
            int'({ep_ce_n, ep_oe_n, ep_pgm_n}), 7);
        chk("R1 supply read level", supply_sel == 2'b00, int'(supply_sel), 0);

        // Plain image, one pulse per byte
        prep(0);
        kick();
        finish_wait();
        expect_pass("A");
        chk("R1 idle after job", ep_ce_n && supply_sel == 2'b00, int'(supply_sel), 0);

        // Varied pulse demands (0xFF target at address 0), start issued mid-job
        prep(1);
        for (int a = 0; a < DEPTH; a++) need[a] = (a % 5) + 1;
        kick();
        repeat (400) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 start ignored while busy", busy, int'(busy), 1);
        finish_wait();
        expect_pass("B");

        // R6 boundary: exactly MAX_PULSES pulses needed
        prep(2);
        need[5] = MAXP;
        kick();
        finish_wait();
        expect_pass("C");

        // R2 not blank in the middle
        prep(0);
        mem[3] = 8'hF7;
        kick();
        finish_wait();
        chk("R2 not_blank flag", not_blank && !fail && !done, int'({done, fail, not_blank}), 1);
        chk("R2 fail_addr", int'(fail_addr) == 3, int'(fail_addr), 3);
        chk("R2 no pulses", total_pulses == 0, total_pulses, 0);
        chk("R2 reads stop at bad byte", reads_blank == 4, reads_blank, 4);
        chk("R2 supply never raised", max_sup == 0, max_sup, 0);

        // R2 not blank at last address
        prep(1);
        mem[DEPTH-1] = 8'h7F;
        kick();
        finish_wait();
        chk("R2 not_blank last", not_blank, int'(not_blank), 1);
        chk("R2 fail_addr last", int'(fail_addr) == DEPTH - 1, int'(fail_addr), DEPTH - 1);
        chk("R2 no pulses last", total_pulses == 0, total_pulses, 0);

        // R6 retry cap exceeded
        prep(0);
        need[5] = MAXP + 1;
        kick();
        finish_wait();
        expect_fail("R6", 5);
        chk("R6 pulses at capped address", pcnt[5] == MAXP, pcnt[5], MAXP);
        chk("R6 later address untouched", pcnt[6] == 0 && mem[6] == 8'hFF, pcnt[6], 0);
        chk("R6 no margin pass", max_sup == 1, max_sup, 1);

        // R7 bit stuck at zero
        prep(0);
        img[4]  = 8'hF0;
        xclr[4] = 8'h80;
        kick();
        finish_wait();
        expect_fail("R7", 4);
        chk("R7 single pulse", pcnt[4] == 1, pcnt[4], 1);

        // R8 high margin mismatch
        prep(2);
        weak_hi[6] = 8'h01;
        kick();
        finish_wait();
        expect_fail("R8 high", 6);
        chk("R8 high reads to fault", reads_hi == 7, reads_hi, 7);
        chk("R8 low pass not entered", reads_lo == 0, reads_lo, 0);

        // R8 low margin mismatch
        prep(1);
        weak_lo[2] = 8'h10;
        kick();
        finish_wait();
        expect_fail("R8 low", 2);
        chk("R8 full high pass", reads_hi == DEPTH, reads_hi, DEPTH);
        chk("R8 low reads to fault", reads_lo == 3, reads_lo, 3);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule